// File: doc/BRIEF.md
# Bus-Cycle-Aware Reset Sequencer

This block decides when the rest of the chip is put into reset and when it is let out again. It accepts three kinds of reset request: an active-low external line that may change at any time, and two synchronous internal pulses, one from a watchdog and one from software. A synchronous active-high power-on input also acts as the block's own reset. The external line passes through a flop chain before any decision is made on it, so only levels present at a clock edge can count.

A request does not take effect at once. The sequencer first raises a hold line toward the bus controller, then waits until no bus cycle is running or the running one signals completion. Only then does it drive its reset outputs, so a write in flight always finishes. Reset is held for a minimum number of clocks and, for as long as the synchronized external line stays low, beyond that. The core reset is released one clock after the peripheral reset. While reset is applied, the mode-select inputs are sampled continually, and the last sample is held as the boot configuration until the next reset. A one-hot cause register records which source started the most recent reset.

Top module: `rstc_top`

## Requirements
- R1: `ext_rst_n` is only seen through a two-flop synchronizer: when it is first sampled low at rising edge k, `bus_hold` rises after edge k+2, and a low pulse that starts and ends between two rising edges has no effect.
- R2: A one-cycle `wdog_req` or `sw_req` sampled high at edge k raises `bus_hold` after edge k; reset outputs rise after the first later edge that samples `bus_busy` low or `bus_done` high.
- R3: `rst_periph` never rises after an edge that sampled `bus_busy` high with `bus_done` low; with the bus held busy, reset stays off indefinitely.
- R4: Once raised by a request, `rst_periph` stays high for at least MIN_HOLD (default 16) clock cycles, exactly MIN_HOLD when the synchronized external line is already high.
- R5: `rst_periph` falls only at an edge where the synchronized external line is high; a long external low stretches the hold to end two edges after the edge that first samples `ext_rst_n` high again.
- R6: `rst_core` rises with `rst_periph` and falls exactly one cycle after it.
- R7: `rst_pin_drv` is high exactly while `rst_periph` is high and the recorded cause is not external, so the chip drives its reset line only for internally caused resets.
- R8: `cause` is one-hot with bit 0 external, bit 1 watchdog, bit 2 power-on, bit 3 software; it is updated when reset is applied; when several requests arrive at the same edge the priority is external, then watchdog, then software; requests arriving while `bus_hold` is high are ignored.
- R9: While `pwr_on_rst` is high all four control outputs are high and `cause` is 4'b0100 (all other bits cleared); reset outputs fall after the MIN_HOLD-th rising edge following the last edge that samples `pwr_on_rst` high.
- R10: `boot_cfg` takes the value of `mode_sel` at every edge during reset (or power-on) and does not change at all while reset is off.
- R11: `bus_hold` is high from the request edge until reset is released, and is always high while `rst_periph` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_on_rst | input | 1 | Synchronous active-high power-on reset, also a reset cause |
| ext_rst_n | input | 1 | Asynchronous active-low external reset request |
| wdog_req | input | 1 | One-cycle watchdog reset request |
| sw_req | input | 1 | One-cycle software reset request |
| bus_busy | input | 1 | A bus cycle is in progress |
| bus_done | input | 1 | The bus cycle in progress ends this clock |
| mode_sel | input | MODE_W | Hardware mode-select pins sampled during reset |
| rst_core | output | 1 | Reset to the processor core, released last |
| rst_periph | output | 1 | Reset to peripherals and bus fabric |
| rst_pin_drv | output | 1 | Enable for driving the chip reset pin outward |
| bus_hold | output | 1 | Asks the bus controller to start no new cycle |
| cause | output | 4 | One-hot record of the last reset source |
| boot_cfg | output | MODE_W | Latched boot configuration |

## Verification
A sequencer stuck in its waiting state shows as `bus_hold` high with no reset outputs, visible within one cycle of the bus going idle; one that skips the wait shows as `rst_periph` rising while `bus_busy` is high. A wrong hold counter shows at the falling edge of `rst_periph` as a hold length other than MIN_HOLD, and a wrongly latched cause shows on `cause` and `rst_pin_drv` in the first reset cycle. A boot latch that keeps capturing after release is exposed by moving `mode_sel` a few cycles after reset ends.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } rst_state_e;

  localparam int CAUSE_W = 4;
  localparam int CB_EXT  = 0;
  localparam int CB_WDOG = 1;
  localparam int CB_POR  = 2;
  localparam int CB_SW   = 3;

  localparam logic [CAUSE_W-1:0] CODE_POR = CAUSE_W'(1) << CB_POR;

  // Priority pick among simultaneous requests: external, watchdog, software
  function automatic logic [CAUSE_W-1:0] pick_cause(input logic ext,
                                                    input logic wd,
                                                    input logic sw);
    logic [CAUSE_W-1:0] c;
    c = '0;
    if (ext)     c[CB_EXT]  = 1'b1;
    else if (wd) c[CB_WDOG] = 1'b1;
    else if (sw) c[CB_SW]   = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic req
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
    end else begin
      chain[0] <= async_n;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign req = ~chain[STAGES-1];
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int MIN_HOLD = 16
) (
  input  logic       clk,
  input  logic       por,
  input  logic       req_any,
  input  logic       ext_req,
  input  logic       bus_busy,
  input  logic       bus_done,
  output rst_state_e state,
  output logic       go_wait,
  output logic       go_hold
);
  localparam int CW = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_HOLD - 1);

  logic [CW-1:0] cnt;
  rst_state_e    nxt;
  logic          bus_free;

  assign bus_free = !bus_busy || bus_done;

  always_comb begin
    nxt     = state;
    go_wait = 1'b0;
    go_hold = 1'b0;
    case (state)
      ST_RUN: if (req_any) begin
        nxt     = ST_WAIT;
        go_wait = 1'b1;
      end
      ST_WAIT: if (bus_free) begin
        nxt     = ST_HOLD;
        go_hold = 1'b1;
      end
      ST_HOLD: if (cnt == LAST && !ext_req) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (go_hold)                               cnt <= '0;
      else if (state == ST_HOLD && cnt != LAST)  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic               clk,
  input  logic               por,
  input  logic               grab,
  input  logic               commit,
  input  logic               ext_req,
  input  logic               wdog_req,
  input  logic               sw_req,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (por) begin
      pend  <= CODE_POR;
      cause <= CODE_POR;
    end else begin
      if (grab)   pend  <= pick_cause(ext_req, wdog_req, sw_req);
      if (commit) cause <= pend;
    end
  end
endmodule

// File: rtl/rstc_bootcfg.sv
module rstc_bootcfg #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              capture,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [MODE_W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (capture) cfg <= mode_sel;
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int MIN_HOLD    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pwr_on_rst,
  input  logic              ext_rst_n,
  input  logic              wdog_req,
  input  logic              sw_req,
  input  logic              bus_busy,
  input  logic              bus_done,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              rst_core,
  output logic              rst_periph,
  output logic              rst_pin_drv,
  output logic              bus_hold,
  output logic [3:0]        cause,
  output logic [MODE_W-1:0] boot_cfg
);
  logic       ext_req;
  logic       req_any;
  rst_state_e state;
  logic       go_wait;
  logic       go_hold;
  logic       in_hold;
  logic       core_lag;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (pwr_on_rst),
    .async_n (ext_rst_n),
    .req     (ext_req)
  );

  assign req_any = ext_req | wdog_req | sw_req;

  rstc_seq #(.MIN_HOLD(MIN_HOLD)) u_seq (
    .clk      (clk),
    .por      (pwr_on_rst),
    .req_any  (req_any),
    .ext_req  (ext_req),
    .bus_busy (bus_busy),
    .bus_done (bus_done),
    .state    (state),
    .go_wait  (go_wait),
    .go_hold  (go_hold)
  );

  rstc_cause u_cause (
    .clk      (clk),
    .por      (pwr_on_rst),
    .grab     (go_wait),
    .commit   (go_hold),
    .ext_req  (ext_req),
    .wdog_req (wdog_req),
    .sw_req   (sw_req),
    .cause    (cause)
  );

  assign in_hold = (state == ST_HOLD);

  rstc_bootcfg #(.MODE_W(MODE_W)) u_boot (
    .clk      (clk),
    .capture  (in_hold | pwr_on_rst),
    .mode_sel (mode_sel),
    .cfg      (boot_cfg)
  );

  // Core reset trails the peripheral reset by one clock on release
  always_ff @(posedge clk) begin
    if (pwr_on_rst) core_lag <= 1'b1;
    else            core_lag <= in_hold;
  end

  assign rst_periph  = in_hold;
  assign rst_core    = in_hold | core_lag;
  assign rst_pin_drv = in_hold & ~cause[CB_EXT];
  assign bus_hold    = (state != ST_RUN);
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int MODE_W   = 4,
  parameter int MIN_HOLD = 16
) (
  input logic              clk,
  input logic              pwr_on_rst,
  input logic              bus_busy,
  input logic              bus_done,
  input logic              ext_req,
  input logic              rst_core,
  input logic              rst_periph,
  input logic              rst_pin_drv,
  input logic              bus_hold,
  input logic [3:0]        cause,
  input logic [MODE_W-1:0] boot_cfg
);
  localparam int LW = $clog2(MIN_HOLD + 1) + 1;

  logic [LW-1:0] hold_len;

  always_ff @(posedge clk) begin
    if (pwr_on_rst)      hold_len <= '0;
    else if (rst_periph) begin
      if (hold_len != '1) hold_len <= hold_len + 1'b1;
    end else             hold_len <= '0;
  end

  assert_rise_gated_R3: assert property (@(posedge clk) disable iff (pwr_on_rst)
    $rose(rst_periph) |-> $past(!bus_busy || bus_done));

  assert_min_hold_R4: assert property (@(posedge clk) disable iff (pwr_on_rst)
    $fell(rst_periph) |-> (hold_len >= LW'(MIN_HOLD)));

  assert_release_ext_R5: assert property (@(posedge clk) disable iff (pwr_on_rst)
    $fell(rst_periph) |-> !$past(ext_req));

  assert_core_lag_R6: assert property (@(posedge clk) disable iff (pwr_on_rst)
    $fell(rst_periph) |-> rst_core);

  assert_core_drop_R6: assert property (@(posedge clk) disable iff (pwr_on_rst)
    $fell(rst_periph) |=> !rst_core);

  assert_pin_drive_R7: assert property (@(posedge clk) disable iff (pwr_on_rst)
    rst_pin_drv |-> (rst_periph && !cause[0]));

  assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (pwr_on_rst)
    $countones(cause) == 1);

  assert_boot_stable_R10: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (!rst_periph && !$past(rst_periph)) |-> $stable(boot_cfg));

  assert_hold_cover_R11: assert property (@(posedge clk) disable iff (pwr_on_rst)
    rst_periph |-> bus_hold);
endmodule

bind rstc_top rstc_chk #(.MODE_W(MODE_W), .MIN_HOLD(MIN_HOLD)) u_chk (
  .clk         (clk),
  .pwr_on_rst  (pwr_on_rst),
  .bus_busy    (bus_busy),
  .bus_done    (bus_done),
  .ext_req     (ext_req),
  .rst_core    (rst_core),
  .rst_periph  (rst_periph),
  .rst_pin_drv (rst_pin_drv),
  .bus_hold    (bus_hold),
  .cause       (cause),
  .boot_cfg    (boot_cfg)
);

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
  localparam int MODE_W   = 4;
  localparam int MIN_HOLD = 16;

  logic              clk;
  logic              pwr_on_rst, ext_rst_n, wdog_req, sw_req, bus_busy, bus_done;
  logic [MODE_W-1:0] mode_sel;
  logic              rst_core, rst_periph, rst_pin_drv, bus_hold;
  logic [3:0]        cause;
  logic [MODE_W-1:0] boot_cfg;

  rstc_top #(.MODE_W(MODE_W), .MIN_HOLD(MIN_HOLD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .pwr_on_rst(pwr_on_rst), .ext_rst_n(ext_rst_n),
    .wdog_req(wdog_req), .sw_req(sw_req), .bus_busy(bus_busy),
    .bus_done(bus_done), .mode_sel(mode_sel), .rst_core(rst_core),
    .rst_periph(rst_periph), .rst_pin_drv(rst_pin_drv), .bus_hold(bus_hold),
    .cause(cause), .boot_cfg(boot_cfg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  typedef struct packed {
    logic       use_ext;
    logic [7:0] ext_len;
    logic       wd;
    logic       sw;
    logic       busy;
    logic [7:0] done_at;
    logic [3:0] mode;
    logic [3:0] exp_cause;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  4'h3, 4'b0010},
    '{1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd6,  4'h5, 4'b1000},
    '{1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 8'd0,  4'h9, 4'b0001},
    '{1'b1, 8'd25, 1'b0, 1'b0, 1'b1, 8'd4,  4'hA, 4'b0001},
    '{1'b0, 8'd0,  1'b1, 1'b1, 1'b0, 8'd0,  4'h6, 4'b0010},
    '{1'b1, 8'd6,  1'b0, 1'b1, 1'b1, 8'd10, 4'hC, 4'b0001},
    '{1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd0,  4'h7, 4'b1000}
  };

  task automatic idle_inputs();
    ext_rst_n = 1'b1; wdog_req = 1'b0; sw_req = 1'b0;
    bus_busy  = 1'b0; bus_done = 1'b0;
  endtask

  // Called at a negedge; returns at a negedge
  task automatic run_vec(input vec_t v);
    int req, ext_i, exit_e, dur;
    int first, last, pin, cz, hreq, hpre, c1, c2;
    req    = v.use_ext ? 2 : 0;
    exit_e = req + 1;
    if (v.busy && int'(v.done_at) > exit_e) exit_e = int'(v.done_at);
    dur = MIN_HOLD;
    if (v.use_ext && (int'(v.ext_len) + 2 - exit_e) > dur) dur = int'(v.ext_len) + 2 - exit_e;
    first = -1; last = -1; pin = -1; cz = -1; hreq = -1; hpre = 0; c1 = -1; c2 = -1;
    mode_sel = v.mode;
    for (int k = 0; k < 80; k++) begin
      ext_i     = (v.use_ext && k < int'(v.ext_len)) ? 0 : 1;
      ext_rst_n = ext_i[0];
      wdog_req  = v.wd && (k == req);
      sw_req    = v.sw && (k == req);
      bus_busy  = v.busy && (k <= int'(v.done_at));
      bus_done  = v.busy && (k == int'(v.done_at));
      @(posedge clk); #2;
      if (rst_periph) begin
        if (first < 0) begin first = k; pin = rst_pin_drv; cz = cause; end
        last = k;
      end
      if (k == req)     hreq = bus_hold;
      if (k == req - 1) hpre = bus_hold;
      if (last >= 0 && k == last + 1) c1 = rst_core;
      if (last >= 0 && k == last + 2) c2 = rst_core;
      @(negedge clk);
    end
    idle_inputs();
    check("R2/R3 reset entry edge", first, exit_e);
    check("R4/R5 hold length", last - first + 1, dur);
    check("R8 cause code", cz, int'(v.exp_cause));
    check("R7 pin drive", pin, v.use_ext ? 0 : 1);
    check("R11 bus_hold at request", hreq, 1);
    check("R1 bus_hold before request", hpre, 0);
    check("R6 core one cycle later", c1, 1);
    check("R6 core released", c2, 0);
    check("R10 boot capture", int'(boot_cfg), int'(v.mode));
    mode_sel = ~v.mode;
    repeat (3) @(negedge clk);
    check("R10 boot stable after release", int'(boot_cfg), int'(v.mode));
  endtask

  initial begin
    int fall, hmax, first, last;
    idle_inputs();
    mode_sel   = 4'hB;
    pwr_on_rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 power-on state
    check("R9 periph in por", rst_periph, 1);
    check("R9 core in por", rst_core, 1);
    check("R9 pin in por", rst_pin_drv, 1);
    check("R11 hold in por", bus_hold, 1);
    check("R9 cause in por", cause, 4'b0100);
    check("R10 boot in por", boot_cfg, 4'hB);
    pwr_on_rst = 1'b0;
    fall = -1;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #2;
      if (!rst_periph && fall < 0) fall = k;
      @(negedge clk);
    end
    check("R9 por release edge", fall, MIN_HOLD - 1);

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i]);
      repeat (4) @(negedge clk);
    end

    // R1: low glitch between edges is never sampled
    hmax = 0;
    #1 ext_rst_n = 1'b0;
    #2 ext_rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #2;
      if (bus_hold || rst_periph) hmax = 1;
      @(negedge clk);
    end
    check("R1 glitch ignored", hmax, 0);

    // R8: request during reset ignored
    first = -1; last = -1;
    for (int k = 0; k < 40; k++) begin
      wdog_req = (k == 0);
      sw_req   = (k == 6);
      @(posedge clk); #2;
      if (rst_periph) begin if (first < 0) first = k; last = k; end
      @(negedge clk);
    end
    idle_inputs();
    check("R8 cause kept on late request", cause, 4'b0010);
    check("R8 late request no extra hold", last - first + 1, MIN_HOLD);
    check("R8 late request no second reset", bus_hold, 0);

    // R9: power-on clears previous cause
    pwr_on_rst = 1'b1;
    @(negedge clk);
    pwr_on_rst = 1'b0;
    check("R9 por overwrites cause", cause, 4'b0100);
    repeat (25) @(negedge clk);

    // R3: a bus that never finishes keeps reset off
    bus_busy = 1'b1;
    wdog_req = 1'b1;
    @(negedge clk);
    wdog_req = 1'b0;
    hmax = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #2;
      if (rst_periph) hmax = 1;
      @(negedge clk);
    end
    check("R3 no reset while busy", hmax, 0);
    check("R11 hold while waiting", bus_hold, 1);
    bus_busy = 1'b0;
    @(posedge clk); #2;
    check("R2 reset once bus idle", rst_periph, 1);
    @(negedge clk);
    repeat (25) @(negedge clk);
    check("R4 released after wait case", rst_periph, 0);

    finish_up();
  end
endmodule